// File: doc/BRIEF.md
# Serial Transmitter with Holding Register and Completion Flags

This block sends 8-bit characters on a single serial line in asynchronous 8N1 framing. Software places a character in a one-entry holding register. The block moves that character into a shift register as soon as the shifter is free. It then sends a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts a fixed number of pulses on an external bit-rate tick input.

Two status flags report progress. The first says the holding register can take another character. The second says both the holding register and the shifter are empty. Each flag has its own interrupt enable, and the enabled flags are ORed into one interrupt request.

The transmit enable controls ownership of the output pin. While enabled, the pin carries the serial line. When the enable is cleared, the block finishes any character already being shifted and drops a queued character. It then hands the pin back to a general-purpose output value, and the hand-over waits for the next bit-rate tick.

Top module: `uart_txq`

## Requirements
- R1: While reset is asserted and after reset releases with the enable low: both flags are 0, `irq` is 0, `pin_owned` is 0, and `txd` equals `gpio_out`.
- R2: When `tx_en` goes from 0 to 1, both `hold_empty` and `tx_done` read 1 on the next cycle. In the same cycle the pin is taken (`pin_owned`=1) and `txd` idles at 1.
- R3: A write (`wr_en`=1) made while `tx_en`=1 and the holding register is free is accepted. On the next cycle `hold_empty` and `tx_done` both read 0.
- R4: A frame is one start bit of value 0, then `DATA_W` data bits least significant first, then one stop bit of value 1. Each bit lasts `TICKS_PER_BIT` bit-rate ticks.
- R5: If the shifter is idle, an accepted character enters it one cycle after the write takes effect, and `hold_empty` returns to 1 at that point. A character waiting behind a busy shifter starts immediately after the stop bit ends, with no idle time between frames.
- R6: `tx_done` is set only when a frame ends and no character is waiting. It stays 0 while frames are chained.
- R7: `irq` is 1 exactly when (`hold_empty` and `empty_ie`) or (`tx_done` and `done_ie`).
- R8: If `tx_en` is cleared while idle, `pin_owned` stays 1 until the next bit-rate tick is consumed. After that it is 0 and `txd` follows `gpio_out`.
- R9: If `tx_en` is cleared during a frame, that frame completes unchanged and any waiting character is discarded and never sent. The flags keep their values until the frame ends, and then both are set. The pin is released at the next tick after the frame ends.
- R10: A write is ignored when `tx_en`=0 or when the holding register already holds a character. It changes neither the flags nor the held character, and it never produces a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; stops the transmitter at once |
| bit_tick | input | 1 | Bit-rate tick; one pulse per sub-bit period |
| tx_en | input | 1 | Transmit enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| empty_ie | input | 1 | Interrupt enable for the holding-empty flag |
| done_ie | input | 1 | Interrupt enable for the transmission-complete flag |
| gpio_out | input | 1 | General-purpose value driven on the pin when not owned |
| txd | output | 1 | Serial output pin |
| pin_owned | output | 1 | 1 while the transmitter owns the pin |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Holding register and shifter both empty |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `DATA_W`=8 and `TICKS_PER_BIT`=4, and drives a tick on every second clock. This uses the counting branch of the bit timer and gives frames of about eighty clocks. With frames that short, the bench can chain two characters, disable in the middle of a frame with a character queued, and then watch a full frame window to confirm the dropped character never appears. Because the tick falls on alternate cycles, the bench can clear the enable in a cycle with no tick and show that the pin is released at the next tick and not before.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

   typedef enum logic {
      SH_IDLE = 1'b0,
      SH_SEND = 1'b1
   } sh_state_t;

   localparam logic LINE_MARK  = 1'b1;
   localparam logic LINE_SPACE = 1'b0;

   // start bit + data + stop bit
   function automatic int frame_bits(input int data_w);
      return data_w + 2;
   endfunction

endpackage

// File: rtl/txq_bit_timer.sv
module txq_bit_timer #(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic bit_tick,
   output logic bit_end
);

   generate
      if (TICKS_PER_BIT == 1) begin : g_direct
         logic unused_direct;
         assign unused_direct = restart | clk | rst_n;
         assign bit_end = run & bit_tick;
      end else begin : g_count
         localparam int CW = $clog2(TICKS_PER_BIT);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (restart) begin
               cnt <= '0;
            end else if (run && bit_tick) begin
               cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
         end

         assign bit_end = run & bit_tick & (cnt == LAST);

         // the counter is parked at zero whenever no frame is running
         assert_cnt_parked_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            !run |-> (cnt == '0));
      end
   endgenerate

endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
   import uart_txq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              bit_end,
   output logic              busy,
   output logic              line,
   output logic              frame_done
);

   localparam int FRAME_W = frame_bits(DATA_W);
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   sh_state_t          state;
   logic [FRAME_W-1:0] shreg;
   logic [IDX_W-1:0]   idx;
   logic               at_last;

   assign at_last = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         shreg <= '1;
         idx   <= '0;
      end else if (load) begin
         state <= SH_SEND;
         shreg <= {LINE_MARK, load_data, LINE_SPACE};
         idx   <= '0;
      end else if ((state == SH_SEND) && bit_end) begin
         if (at_last) begin
            state <= SH_IDLE;
            shreg <= '1;
            idx   <= '0;
         end else begin
            shreg <= {LINE_MARK, shreg[FRAME_W-1:1]};
            idx   <= idx + 1'b1;
         end
      end
   end

   assign busy       = (state == SH_SEND);
   assign line       = busy ? shreg[0] : LINE_MARK;
   assign frame_done = busy & bit_end & at_last;

   // a loaded frame opens with a start bit
   assert_start_bit_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (busy && (line == LINE_SPACE)));

   // the last bit of every frame is the stop bit
   assert_stop_last_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (line == LINE_MARK));

endmodule

// File: rtl/txq_holding.sv
module txq_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   input  logic              frame_done,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_empty,
   output logic              tx_done
);

   logic en_q;
   logic en_rise;
   logic wr_ok;
   logic drained;

   assign en_rise = tx_en & ~en_q;
   assign wr_ok   = wr_en & tx_en & ~hold_valid;
   assign drained = frame_done & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         hold_valid <= 1'b0;
         hold_data  <= '0;
         hold_empty <= 1'b0;
         tx_done    <= 1'b0;
      end else begin
         en_q <= tx_en;

         if (!tx_en) begin
            hold_valid <= 1'b0;
         end else if (load) begin
            hold_valid <= 1'b0;
         end else if (wr_ok) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
         end

         if (wr_ok) begin
            hold_empty <= 1'b0;
         end else if (en_rise || load || drained) begin
            hold_empty <= 1'b1;
         end

         if (wr_ok) begin
            tx_done <= 1'b0;
         end else if (en_rise || drained) begin
            tx_done <= 1'b1;
         end
      end
   end

   assert_wr_clears_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_en && !hold_valid) |=> (hold_valid && !hold_empty && !tx_done));

   assert_enable_sets_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !en_q && !wr_en) |=> (hold_empty && tx_done));

   assert_drop_disabled_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !hold_valid);

   assert_full_keeps_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold_valid && tx_en && !load) |=> (hold_valid && $stable(hold_data)));

endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              empty_ie,
   input  logic              done_ie,
   input  logic              gpio_out,
   output logic              txd,
   output logic              pin_owned,
   output logic              hold_empty,
   output logic              tx_done,
   output logic              irq
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("uart_txq: DATA_W must be at least 1");
      end
      if (TICKS_PER_BIT < 1) begin : g_bad_ticks
         $error("uart_txq: TICKS_PER_BIT must be at least 1");
      end
   endgenerate

   logic              busy;
   logic              line;
   logic              frame_done;
   logic              bit_end;
   logic              load;
   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;
   logic              owned_q;

   assign load = hold_valid & tx_en & (~busy | frame_done);

   txq_bit_timer #(
      .TICKS_PER_BIT(TICKS_PER_BIT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .restart  (load),
      .bit_tick (bit_tick),
      .bit_end  (bit_end)
   );

   txq_shifter #(
      .DATA_W(DATA_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_data  (hold_data),
      .bit_end    (bit_end),
      .busy       (busy),
      .line       (line),
      .frame_done (frame_done)
   );

   txq_holding #(
      .DATA_W(DATA_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_en),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .load       (load),
      .frame_done (frame_done),
      .hold_valid (hold_valid),
      .hold_data  (hold_data),
      .hold_empty (hold_empty),
      .tx_done    (tx_done)
   );

   // pin ownership: taken with the enable, returned on a tick once idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owned_q <= 1'b0;
      end else if (tx_en) begin
         owned_q <= 1'b1;
      end else if (bit_tick && !busy) begin
         owned_q <= 1'b0;
      end
   end

   assign pin_owned = owned_q;
   assign txd       = owned_q ? line : gpio_out;
   assign irq       = (hold_empty & empty_ie) | (tx_done & done_ie);

   assert_busy_owns_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> pin_owned);

   assert_release_tick_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_owned) |-> $past(bit_tick));

   assert_no_start_disabled_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !busy) |=> !busy);

   assert_irq_source_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (empty_ie || done_ie));

endmodule

// File: tb/uart_txq_test.sv
`timescale 1ns/1ps
module uart_txq_test;

   localparam int DW  = 8;
   localparam int TPB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 1'b0;
   logic          tx_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          empty_ie = 1'b0;
   logic          done_ie = 1'b0;
   logic          gpio_out = 1'b0;
   logic          txd, pin_owned, hold_empty, tx_done, irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [DW-1:0] rx_data;
   logic          rx_seen, rx_start, rx_stop;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) bit_tick <= ~bit_tick;
      else       bit_tick <= 1'b0;
   end

   uart_txq #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) uut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
      .wr_en(wr_en), .wr_data(wr_data), .empty_ie(empty_ie), .done_ie(done_ie),
      .gpio_out(gpio_out), .txd(txd), .pin_owned(pin_owned),
      .hold_empty(hold_empty), .tx_done(tx_done), .irq(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [DW-1:0] d);
      step();
      wr_en = 1'b1;
      wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rx_frame();
      int w;
      int n;
      int target;
      rx_seen = 1'b0;
      w = 0;
      while (txd !== 1'b0 && w < 800) begin
         step();
         w++;
      end
      if (txd !== 1'b0) return;
      rx_seen = 1'b1;
      n = 0;
      target = TPB / 2;
      for (int b = 0; b < DW + 2; b++) begin
         while (n < target) begin
            step();
            if (bit_tick) n++;
         end
         if (b == 0)           rx_start = (txd === 1'b0);
         else if (b == DW + 1) rx_stop  = (txd === 1'b1);
         else                  rx_data[b-1] = txd;
         target += TPB;
      end
   endtask

   task automatic check_frame(input string req, input logic [DW-1:0] exp);
      chk(req, "frame seen", rx_seen, 1);
      chk(req, "start bit low", rx_start, 1);
      chk(req, "data lsb first", rx_data, exp);
      chk(req, "stop bit high", rx_stop, 1);
   endtask

   task automatic watch_quiet(input string req, input int cycles);
      int lows;
      lows = 0;
      for (int i = 0; i < cycles; i++) begin
         step();
         if (txd !== 1'b1) lows++;
      end
      chk(req, "no frame on line", lows, 0);
   endtask

   task automatic t_reset();
      gpio_out = 1'b0;
      repeat (3) step();
      chk("R1", "txd in reset follows gpio", txd, 0);
      rst_n = 1'b1;
      step();
      chk("R1", "hold_empty", hold_empty, 0);
      chk("R1", "tx_done", tx_done, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "pin_owned", pin_owned, 0);
      gpio_out = 1'b1;
      step();
      chk("R1", "txd follows gpio high", txd, 1);
   endtask

   task automatic t_enable();
      gpio_out = 1'b0;
      tx_en = 1'b1;
      step();
      chk("R2", "hold_empty set", hold_empty, 1);
      chk("R2", "tx_done set", tx_done, 1);
      chk("R2", "pin taken", pin_owned, 1);
      chk("R2", "line idles high", txd, 1);
   endtask

   task automatic t_irq();
      empty_ie = 1'b0; done_ie = 1'b0; step();
      chk("R7", "no enables", irq, 0);
      empty_ie = 1'b1; step();
      chk("R7", "empty enabled", irq, 1);
      empty_ie = 1'b0; done_ie = 1'b1; step();
      chk("R7", "done enabled", irq, 1);
   endtask

   task automatic t_single();
      empty_ie = 1'b0; done_ie = 1'b1;
      fork
         rx_frame();
         begin
            wr(8'hA5);
            chk("R3", "hold_empty cleared", hold_empty, 0);
            chk("R3", "tx_done cleared", tx_done, 0);
            chk("R7", "irq low with flags clear", irq, 0);
            step();
            chk("R5", "idle transfer frees holding", hold_empty, 1);
            chk("R6", "tx_done low while sending", tx_done, 0);
         end
      join
      check_frame("R4", 8'hA5);
      chk("R6", "tx_done low in stop bit", tx_done, 0);
      repeat (8) step();
      chk("R6", "tx_done after last frame", tx_done, 1);
      chk("R7", "irq from done flag", irq, 1);
      empty_ie = 1'b1; done_ie = 1'b0; step();
      chk("R7", "irq from empty flag", irq, 1);
      empty_ie = 1'b0; step();
      chk("R7", "irq masked", irq, 0);
   endtask

   task automatic t_chain();
      int g;
      fork
         begin
            rx_frame();
            check_frame("R4", 8'h3C);
            g = 0;
            while (txd !== 1'b0 && g < 20) begin
               step();
               g++;
            end
            chk("R5", "no gap between frames", (g <= 8), 1);
            chk("R6", "tx_done low across chain", tx_done, 0);
            chk("R5", "holding freed at chain start", hold_empty, 1);
            rx_frame();
         end
         begin
            wr(8'h3C);
            step();
            wr(8'hC3);
            chk("R5", "holding full behind shifter", hold_empty, 0);
            wr(8'hFF);
            chk("R10", "write while full keeps flag", hold_empty, 0);
         end
      join
      check_frame("R4", 8'hC3);
      chk("R10", "full write did not overwrite", rx_data, 8'hC3);
      repeat (10) step();
      chk("R6", "tx_done after chain", tx_done, 1);
      watch_quiet("R10", 100);
   endtask

   task automatic t_release_idle();
      gpio_out = 1'b0;
      step();
      while (bit_tick) step();
      tx_en = 1'b0;
      step();
      chk("R8", "pin kept until tick", pin_owned, 1);
      chk("R8", "line still high", txd, 1);
      step();
      chk("R8", "pin released on tick", pin_owned, 0);
      chk("R8", "txd follows gpio low", txd, 0);
      gpio_out = 1'b1;
      step();
      chk("R8", "txd follows gpio high", txd, 1);
      wr(8'h00);
      chk("R10", "disabled write keeps hold_empty", hold_empty, 1);
      chk("R10", "disabled write keeps tx_done", tx_done, 1);
      gpio_out = 1'b0;
      step();
      chk("R10", "pin still general purpose", txd, 0);
      gpio_out = 1'b1;
      tx_en = 1'b1;
      watch_quiet("R10", 100);
   endtask

   task automatic t_graceful();
      fork
         rx_frame();
         begin
            wr(8'h5A);
            step();
            wr(8'h81);
            repeat (20) step();
            tx_en = 1'b0;
            gpio_out = 1'b0;
         end
      join
      check_frame("R9", 8'h5A);
      chk("R9", "pin held through frame", pin_owned, 1);
      chk("R9", "hold_empty waits for end", hold_empty, 0);
      chk("R9", "tx_done waits for end", tx_done, 0);
      repeat (10) step();
      chk("R9", "hold_empty set at end", hold_empty, 1);
      chk("R9", "tx_done set at end", tx_done, 1);
      chk("R9", "pin released after end", pin_owned, 0);
      chk("R9", "txd follows gpio", txd, 0);
      gpio_out = 1'b1;
      tx_en = 1'b1;
      watch_quiet("R9", 120);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      t_reset();
      t_enable();
      t_irq();
      t_single();
      t_chain();
      t_release_idle();
      t_graceful();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL all watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule